// File: doc/BRIEF.md
# Single-Byte Buffered Serial Port

This block is a serial port that sits on a 32-bit register bus with APB-style timing. It has a one-byte transmit holding buffer and a one-byte receive holding buffer. Frames are fixed at 8 data bits, least significant bit first, with no parity and one stop bit. A programmable divider sets how many bus clocks each bit lasts. Software writes a byte, and the transmitter moves it into its shift register as soon as transmission is enabled. A received byte waits in the holding buffer until software reads it. Any byte that arrives while the receive buffer is still occupied is counted as an overrun.

Each event has a sticky flag that software clears by writing a one to it. There are three interrupt lines. The transmit line and the receive line each follow their own flag and enable bit. The overrun line is shared by the transmit overrun and the receive overrun. A bus access completes in the cycle where `psel` and `penable` are both high, and there are no wait states. Read data is combinational from the address during that cycle.

The transmitter has four states: `TX_IDLE`, `TX_START`, `TX_DATA` and `TX_STOP`.
- `TX_IDLE` goes to `TX_START` when transmission is enabled and the buffer is full. On this step the byte is taken and the transmit flag is set.
- `TX_START` goes to `TX_DATA`, and `TX_STOP` goes back to `TX_IDLE`, after one bit period each.
- `TX_DATA` goes to `TX_STOP` after the eighth bit period.

The receiver has four states: `RX_IDLE`, `RX_START`, `RX_DATA` and `RX_STOP`.
- `RX_IDLE` goes to `RX_START` on a falling edge of the synchronised line while reception is enabled.
- `RX_START` checks the line at half a bit period. It goes to `RX_DATA` if the line is still low, and back to `RX_IDLE` if it is not.
- `RX_DATA` samples one bit per period and goes to `RX_STOP` after the eighth bit.
- `RX_STOP` returns to `RX_IDLE` at the middle of the stop bit. It delivers the byte only if the line is high there.

Top module: `sbuf_uart`

## Requirements
- R1: After reset the control register is 0, the divider is 16, the state and interrupt registers are 0, `txd` is high and all three interrupt lines are low.
- R2: The registers are at these offsets: received/transmit byte 0x00, state 0x04, control 0x08, interrupt flags 0x0C, divider 0x10. Reads of any other offset return 0.
- R3: A write to 0x00 while the transmit buffer is empty stores the byte and sets state bit 0 (transmit full). While control bit 0 (transmit enable) is 0, the byte stays held and bit 0 stays set.
- R4: When control bit 0 is set, a held byte is sent on `txd` as one frame. The frame is a low start bit, then 8 data bits with bit 0 first, then a high stop bit, each bit lasting the divider count of clocks. State bit 0 clears when the byte is taken.
- R5: Interrupt flag bit 0 sets when the byte leaves the transmit buffer. `irq_tx` is flag bit 0 AND control bit 2.
- R6: A write to 0x00 while state bit 0 is set discards the written byte and sets state bit 2 and interrupt flag bit 2.
- R7: When control bit 1 (receive enable) is set, a valid frame on `rxd` sets state bit 1 (receive full) and interrupt flag bit 1, and the byte becomes readable. `irq_rx` is flag bit 1 AND control bit 3.
- R8: Reading 0x00 returns the received byte in bits 7:0 and clears state bit 1.
- R9: A frame that completes while state bit 1 is set is discarded. The previously held byte is kept, and state bit 3 and interrupt flag bit 3 are set.
- R10: A frame whose stop bit samples low is dropped without setting any flag. A low pulse shorter than half a bit period does not start a frame.
- R11: `irq_ovr` is (flag bit 2 AND control bit 4) OR (flag bit 3 AND control bit 5).
- R12: Writing ones to 0x0C clears the matching flags, and writing zeros there has no effect. Writing ones to bits 2 or 3 of 0x04 clears the matching state overrun bits without touching the interrupt flags.
- R13: The divider holds 21 bits. A write of a value below 16 stores 16.
- R14: While control bit 1 is 0, traffic on `rxd` changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and bit-timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 5 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line, idles high |
| irq_tx | output | 1 | Transmit buffer freed interrupt |
| irq_rx | output | 1 | Byte received interrupt |
| irq_ovr | output | 1 | Transmit or receive overrun interrupt |

## Verification
A transmitter state that is stuck or skips a step shows up on `txd` within one bit period. It appears as a missing start bit, a shifted data bit or a short frame. A wrong transmit-full bit appears either as a held byte that is sent anyway, or as a frame that never starts.

A receiver that loses bit alignment or skips the mid-start check delivers a wrong byte, or flags a line glitch as data. This is visible at the next state-register read after the frame. Flag and overrun errors show directly on the three interrupt lines in the cycle after the event.

// File: rtl/sbuf_uart_pkg.sv
package sbuf_uart_pkg;

    localparam int ADDR_W    = 5;
    localparam int DATA_BITS = 8;

    localparam logic [ADDR_W-1:0] OFF_BYTE  = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_STATE = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_FLAGS = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_DIV   = 5'h10;

    // control bit positions
    localparam int CB_TX_EN     = 0;
    localparam int CB_RX_EN     = 1;
    localparam int CB_TX_IE     = 2;
    localparam int CB_RX_IE     = 3;
    localparam int CB_TX_OVR_IE = 4;
    localparam int CB_RX_OVR_IE = 5;
    localparam int CTRL_W       = 6;

    // flag positions shared by state and interrupt registers
    localparam int FB_TX     = 0;
    localparam int FB_RX     = 1;
    localparam int FB_TX_OVR = 2;
    localparam int FB_RX_OVR = 3;
    localparam int FLAG_W    = 4;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

endpackage

// File: rtl/sbuf_uart_tx.sv
module sbuf_uart_tx
    import sbuf_uart_pkg::*;
#(
    parameter int DIV_W = 21
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [DIV_W-1:0]     div,
    input  logic                 buf_full,
    input  logic [DATA_BITS-1:0] buf_byte,
    output logic                 take,
    output logic                 busy,
    output logic                 txd
);

    localparam int BIT_W = $clog2(DATA_BITS);

    tx_state_e             state_q, state_d;
    logic [DIV_W-1:0]      cnt_q;
    logic [BIT_W-1:0]      bit_q;
    logic [DATA_BITS-1:0]  shift_q;
    logic                  bit_end;
    logic                  last_bit;

    assign bit_end  = (cnt_q >= div - 1'b1);
    assign last_bit = (bit_q == BIT_W'(DATA_BITS - 1));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (en && buf_full)      state_d = TX_START;
            TX_START: if (bit_end)             state_d = TX_DATA;
            TX_DATA:  if (bit_end && last_bit) state_d = TX_STOP;
            TX_STOP:  if (bit_end)             state_d = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // bit timing and shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            shift_q <= '1;
        end else begin
            if (state_q == TX_IDLE || bit_end) cnt_q <= '0;
            else                               cnt_q <= cnt_q + 1'b1;

            if (state_q != TX_DATA)  bit_q <= '0;
            else if (bit_end)        bit_q <= bit_q + 1'b1;

            if (take)                               shift_q <= buf_byte;
            else if (state_q == TX_DATA && bit_end) shift_q <= shift_q >> 1;
        end
    end

    // outputs
    always_comb begin
        take = 1'b0;
        busy = 1'b1;
        txd  = 1'b1;
        unique case (state_q)
            TX_IDLE: begin
                busy = 1'b0;
                take = en && buf_full;
            end
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shift_q[0];
            TX_STOP:  txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/sbuf_uart_rx.sv
module sbuf_uart_rx
    import sbuf_uart_pkg::*;
#(
    parameter int DIV_W = 21
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [DIV_W-1:0]     div,
    input  logic                 line,
    output logic                 load,
    output logic [DATA_BITS-1:0] rx_byte
);

    localparam int BIT_W = $clog2(DATA_BITS);

    rx_state_e             state_q, state_d;
    logic [DIV_W-1:0]      cnt_q;
    logic [BIT_W-1:0]      bit_q;
    logic [DATA_BITS-1:0]  shift_q;
    logic                  prev_q;
    logic                  fall;
    logic                  bit_end;
    logic                  mid_hit;
    logic                  last_bit;
    logic                  advance;

    assign fall     = prev_q && !line;
    assign bit_end  = (cnt_q >= div - 1'b1);
    assign mid_hit  = (cnt_q >= (div >> 1) - 1'b1);
    assign last_bit = (bit_q == BIT_W'(DATA_BITS - 1));

    // next state
    always_comb begin
        state_d = state_q;
        advance = 1'b0;
        unique case (state_q)
            RX_IDLE:  if (en && fall) state_d = RX_START;
            RX_START: begin
                advance = mid_hit;
                if (mid_hit) state_d = line ? RX_IDLE : RX_DATA;
            end
            RX_DATA: begin
                advance = bit_end;
                if (bit_end && last_bit) state_d = RX_STOP;
            end
            RX_STOP: begin
                advance = bit_end;
                if (bit_end) state_d = RX_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // timing, edge detect and shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            shift_q <= '0;
            prev_q  <= 1'b1;
        end else begin
            prev_q <= line;

            if (state_q == RX_IDLE || advance) cnt_q <= '0;
            else                               cnt_q <= cnt_q + 1'b1;

            if (state_q != RX_DATA) bit_q <= '0;
            else if (bit_end)       bit_q <= bit_q + 1'b1;

            if (state_q == RX_DATA && bit_end)
                shift_q <= {line, shift_q[DATA_BITS-1:1]};
        end
    end

    // outputs
    always_comb begin
        load    = (state_q == RX_STOP) && bit_end && line;
        rx_byte = shift_q;
    end

endmodule

// File: rtl/sbuf_uart_regs.sv
module sbuf_uart_regs
    import sbuf_uart_pkg::*;
#(
    parameter int DIV_W   = 21,
    parameter int DIV_MIN = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wdata,
    input  logic                 tx_take,
    input  logic                 rx_load,
    input  logic [DATA_BITS-1:0] rx_byte,
    output logic [31:0]          rdata,
    output logic [CTRL_W-1:0]    ctrl,
    output logic [DIV_W-1:0]     div,
    output logic                 tx_full,
    output logic [DATA_BITS-1:0] tx_byte,
    output logic                 rx_full,
    output logic [1:0]           ovr,
    output logic                 irq_tx,
    output logic                 irq_rx,
    output logic                 irq_ovr
);

    localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(DIV_MIN);

    logic [DATA_BITS-1:0] rx_hold_q;
    logic [FLAG_W-1:0]    flags_q;
    logic                 wr_byte, wr_state, wr_ctrl, wr_flags, wr_div;
    logic                 rd_byte;
    logic                 rx_busy_slot;
    logic [DIV_W-1:0]     div_in;
    logic                 unused_wdata;

    assign wr_byte  = wr_en && (addr == OFF_BYTE);
    assign wr_state = wr_en && (addr == OFF_STATE);
    assign wr_ctrl  = wr_en && (addr == OFF_CTRL);
    assign wr_flags = wr_en && (addr == OFF_FLAGS);
    assign wr_div   = wr_en && (addr == OFF_DIV);
    assign rd_byte  = rd_en && (addr == OFF_BYTE);
    assign div_in   = wdata[DIV_W-1:0];
    assign rx_busy_slot = rx_full && !rd_byte;
    assign unused_wdata = ^wdata[31:DIV_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl      <= '0;
            div       <= DIV_FLOOR;
            tx_full   <= 1'b0;
            tx_byte   <= '0;
            rx_full   <= 1'b0;
            rx_hold_q <= '0;
            ovr       <= '0;
            flags_q   <= '0;
        end else begin
            if (wr_ctrl) ctrl <= wdata[CTRL_W-1:0];
            if (wr_div)  div  <= (div_in < DIV_FLOOR) ? DIV_FLOOR : div_in;

            // clears first, event sets below take precedence
            if (wr_state) begin
                if (wdata[FB_TX_OVR]) ovr[0] <= 1'b0;
                if (wdata[FB_RX_OVR]) ovr[1] <= 1'b0;
            end
            if (wr_flags) flags_q <= flags_q & ~wdata[FLAG_W-1:0];

            // transmit holding buffer
            if (tx_take) begin
                tx_full        <= 1'b0;
                flags_q[FB_TX] <= 1'b1;
            end
            if (wr_byte) begin
                if (tx_full) begin
                    ovr[0]             <= 1'b1;
                    flags_q[FB_TX_OVR] <= 1'b1;
                end else begin
                    tx_byte <= wdata[DATA_BITS-1:0];
                    tx_full <= 1'b1;
                end
            end

            // receive holding buffer
            if (rd_byte) rx_full <= 1'b0;
            if (rx_load) begin
                if (rx_busy_slot) begin
                    ovr[1]             <= 1'b1;
                    flags_q[FB_RX_OVR] <= 1'b1;
                end else begin
                    rx_hold_q      <= rx_byte;
                    rx_full        <= 1'b1;
                    flags_q[FB_RX] <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFF_BYTE:  rdata[DATA_BITS-1:0] = rx_hold_q;
            OFF_STATE: rdata[FLAG_W-1:0]    = {ovr[1], ovr[0], rx_full, tx_full};
            OFF_CTRL:  rdata[CTRL_W-1:0]    = ctrl;
            OFF_FLAGS: rdata[FLAG_W-1:0]    = flags_q;
            OFF_DIV:   rdata[DIV_W-1:0]     = div;
            default:   rdata = '0;
        endcase
    end

    assign irq_tx  = flags_q[FB_TX] && ctrl[CB_TX_IE];
    assign irq_rx  = flags_q[FB_RX] && ctrl[CB_RX_IE];
    assign irq_ovr = (flags_q[FB_TX_OVR] && ctrl[CB_TX_OVR_IE]) ||
                     (flags_q[FB_RX_OVR] && ctrl[CB_RX_OVR_IE]);

endmodule

// File: rtl/sbuf_uart.sv
module sbuf_uart
    import sbuf_uart_pkg::*;
#(
    parameter int DIV_W       = 21,
    parameter int DIV_MIN     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic              rxd,
    output logic              txd,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_ovr
);

    logic                   wr_en, rd_en;
    logic [CTRL_W-1:0]      ctrl;
    logic [DIV_W-1:0]       div;
    logic                   tx_full, tx_take, tx_busy;
    logic [DATA_BITS-1:0]   tx_byte;
    logic                   rx_full, rx_load;
    logic [DATA_BITS-1:0]   rx_byte;
    logic [1:0]             ovr;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_line;

    assign wr_en = psel && penable && pwrite;
    assign rd_en = psel && penable && !pwrite;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
    end
    assign rx_line = sync_q[SYNC_STAGES-1];

    sbuf_uart_regs #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (paddr),
        .wdata   (pwdata),
        .tx_take (tx_take),
        .rx_load (rx_load),
        .rx_byte (rx_byte),
        .rdata   (prdata),
        .ctrl    (ctrl),
        .div     (div),
        .tx_full (tx_full),
        .tx_byte (tx_byte),
        .rx_full (rx_full),
        .ovr     (ovr),
        .irq_tx  (irq_tx),
        .irq_rx  (irq_rx),
        .irq_ovr (irq_ovr)
    );

    sbuf_uart_tx #(.DIV_W(DIV_W)) i_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctrl[CB_TX_EN]),
        .div      (div),
        .buf_full (tx_full),
        .buf_byte (tx_byte),
        .take     (tx_take),
        .busy     (tx_busy),
        .txd      (txd)
    );

    sbuf_uart_rx #(.DIV_W(DIV_W)) i_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl[CB_RX_EN]),
        .div     (div),
        .line    (rx_line),
        .load    (rx_load),
        .rx_byte (rx_byte)
    );

endmodule

// File: rtl/sbuf_uart_checker.sv
module sbuf_uart_checker
    import sbuf_uart_pkg::*;
#(
    parameter int DIV_W   = 21,
    parameter int DIV_MIN = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic              tx_en,
    input logic              tx_full,
    input logic              tx_busy,
    input logic              rx_full,
    input logic              rx_load,
    input logic [1:0]        ovr,
    input logic [DIV_W-1:0]  div
);

    logic wr_byte;
    assign wr_byte = psel && penable && pwrite && (paddr == OFF_BYTE);

    assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && tx_full) |=> tx_full);

    assert_tx_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(tx_full));

    assert_tx_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte && tx_full) |=> ovr[0]);

    assert_rx_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load && !rx_full) |=> rx_full);

    assert_rx_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr[1]) |-> $past(rx_full));

    assert_div_floor_R13: assert property (@(posedge clk) disable iff (!rst_n)
        div >= DIV_W'(DIV_MIN));

endmodule

bind sbuf_uart sbuf_uart_checker #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .tx_en   (ctrl[0]),
    .tx_full (tx_full),
    .tx_busy (tx_busy),
    .rx_full (rx_full),
    .rx_load (rx_load),
    .ovr     (ovr),
    .div     (div)
);

// File: tb/test_sbuf_uart.sv
module test_sbuf_uart;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [4:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        rxd, txd, irq_tx, irq_rx, irq_ovr;
    logic        rxd_drv = 1'b1;
    logic        loop = 1'b0;
    int          checks = 0, errors = 0;
    int          bit_cyc = 16;

    localparam logic [4:0] A_BYTE = 5'h00, A_STATE = 5'h04, A_CTRL = 5'h08,
                           A_FLAGS = 5'h0C, A_DIV = 5'h10;

    assign rxd = loop ? txd : rxd_drv;

    always #4 clk = ~clk;

    sbuf_uart i_sbuf_uart (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .rxd(rxd), .txd(txd),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_ovr(irq_ovr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic expect_reg(input string tag, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        check(tag, v, exp);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop_bit);
        @(negedge clk);
        rxd_drv = 1'b0;
        repeat (bit_cyc) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd_drv = b[i];
            repeat (bit_cyc) @(negedge clk);
        end
        rxd_drv = stop_bit;
        repeat (bit_cyc) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (bit_cyc) @(negedge clk);
    endtask

    task automatic catch_frame(input string tag, input logic [7:0] exp);
        logic [7:0] b;
        logic       st, sp;
        b = '0;
        for (int n = 0; n < 4000 && txd !== 1'b0; n++) @(negedge clk);
        repeat (bit_cyc / 2) @(negedge clk);
        st = txd;
        for (int i = 0; i < 8; i++) begin
            repeat (bit_cyc) @(negedge clk);
            b[i] = txd;
        end
        repeat (bit_cyc) @(negedge clk);
        sp = txd;
        check({tag, " start bit"}, {31'd0, st}, 32'd0);
        check({tag, " data"}, {24'd0, b}, {24'd0, exp});
        check({tag, " stop bit"}, {31'd0, sp}, 32'd1);
    endtask

    task automatic test_reset;
        check("R1 txd idle", {31'd0, txd}, 32'd1);
        check("R1 irqs low", {29'd0, irq_tx, irq_rx, irq_ovr}, 32'd0);
        expect_reg("R1 ctrl", A_CTRL, 32'd0);
        expect_reg("R1 div", A_DIV, 32'd16);
        expect_reg("R1 state", A_STATE, 32'd0);
        expect_reg("R1 flags", A_FLAGS, 32'd0);
        expect_reg("R2 unmapped 0x14", 5'h14, 32'd0);
        expect_reg("R2 unmapped 0x1C", 5'h1C, 32'd0);
    endtask

    task automatic test_tx;
        bus_write(A_CTRL, 32'h0);
        bus_write(A_BYTE, 32'hA5);
        expect_reg("R3 full after write", A_STATE, 32'h1);
        repeat (40) @(negedge clk);
        expect_reg("R3 held while disabled", A_STATE, 32'h1);
        check("R3 txd idle while held", {31'd0, txd}, 32'd1);
        expect_reg("R5 no flag before take", A_FLAGS, 32'h0);
        bus_write(A_CTRL, 32'h1);
        catch_frame("R4 frame A5", 8'hA5);
        expect_reg("R4 empty after take", A_STATE, 32'h0);
        expect_reg("R5 tx flag", A_FLAGS, 32'h1);
        check("R5 irq_tx masked", {31'd0, irq_tx}, 32'd0);
        bus_write(A_CTRL, 32'h5);
        check("R5 irq_tx enabled", {31'd0, irq_tx}, 32'd1);
        bus_write(A_FLAGS, 32'h0);
        expect_reg("R12 zero write keeps flag", A_FLAGS, 32'h1);
        bus_write(A_FLAGS, 32'h1);
        expect_reg("R12 one clears flag", A_FLAGS, 32'h0);
        check("R5 irq_tx after clear", {31'd0, irq_tx}, 32'd0);
        repeat (bit_cyc) @(negedge clk);
    endtask

    task automatic test_tx_overrun;
        bus_write(A_CTRL, 32'h0);
        bus_write(A_BYTE, 32'h11);
        bus_write(A_BYTE, 32'h22);
        expect_reg("R6 state overrun", A_STATE, 32'h5);
        expect_reg("R6 flag overrun", A_FLAGS, 32'h4);
        check("R11 irq_ovr masked", {31'd0, irq_ovr}, 32'd0);
        bus_write(A_CTRL, 32'h10);
        check("R11 irq_ovr tx cause", {31'd0, irq_ovr}, 32'd1);
        bus_write(A_STATE, 32'h4);
        expect_reg("R12 state clear", A_STATE, 32'h1);
        expect_reg("R12 state clear leaves flag", A_FLAGS, 32'h4);
        bus_write(A_FLAGS, 32'h4);
        check("R11 irq_ovr cleared", {31'd0, irq_ovr}, 32'd0);
        bus_write(A_CTRL, 32'h11);
        catch_frame("R6 first byte kept", 8'h11);
        repeat (bit_cyc) @(negedge clk);
        bus_write(A_FLAGS, 32'hF);
    endtask

    task automatic test_rx;
        bus_write(A_CTRL, 32'h2);
        send_frame(8'h3C, 1'b1);
        expect_reg("R7 rx full", A_STATE, 32'h2);
        check("R7 irq_rx masked", {31'd0, irq_rx}, 32'd0);
        bus_write(A_CTRL, 32'hA);
        check("R7 irq_rx enabled", {31'd0, irq_rx}, 32'd1);
        expect_reg("R7 rx flag", A_FLAGS, 32'h2);
        expect_reg("R8 read byte", A_BYTE, 32'h3C);
        expect_reg("R8 rx empty after read", A_STATE, 32'h0);
        bus_write(A_FLAGS, 32'h2);
        check("R12 irq_rx cleared", {31'd0, irq_rx}, 32'd0);
    endtask

    task automatic test_rx_overrun;
        bus_write(A_CTRL, 32'h22);
        send_frame(8'h01, 1'b1);
        send_frame(8'h02, 1'b1);
        expect_reg("R9 state overrun", A_STATE, 32'hA);
        expect_reg("R9 flags", A_FLAGS, 32'hA);
        check("R11 irq_ovr rx cause", {31'd0, irq_ovr}, 32'd1);
        expect_reg("R9 old byte kept", A_BYTE, 32'h01);
        bus_write(A_STATE, 32'h8);
        expect_reg("R12 rx overrun state clear", A_STATE, 32'h0);
        bus_write(A_FLAGS, 32'hF);
        check("R11 irq_ovr after clear", {31'd0, irq_ovr}, 32'd0);
    endtask

    task automatic test_rx_errors;
        bus_write(A_CTRL, 32'h2);
        send_frame(8'h77, 1'b0);
        expect_reg("R10 bad stop dropped", A_STATE, 32'h0);
        expect_reg("R10 bad stop no flag", A_FLAGS, 32'h0);
        @(negedge clk);
        rxd_drv = 1'b0;
        repeat (3) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (12 * bit_cyc) @(negedge clk);
        expect_reg("R10 glitch ignored", A_STATE, 32'h0);
        send_frame(8'h5A, 1'b1);
        expect_reg("R10 recovery byte", A_BYTE, 32'h5A);
        bus_write(A_FLAGS, 32'hF);
    endtask

    task automatic test_rx_disabled;
        bus_write(A_CTRL, 32'h0);
        send_frame(8'h99, 1'b1);
        expect_reg("R14 state unchanged", A_STATE, 32'h0);
        expect_reg("R14 flags unchanged", A_FLAGS, 32'h0);
    endtask

    task automatic test_div;
        bus_write(A_DIV, 32'd5);
        expect_reg("R13 clamp", A_DIV, 32'd16);
        bus_write(A_DIV, 32'hFFFF_FFFF);
        expect_reg("R13 full width", A_DIV, 32'h001F_FFFF);
        bus_write(A_DIV, 32'd32);
        expect_reg("R13 store 32", A_DIV, 32'd32);
        bit_cyc = 32;
        loop = 1'b1;
        bus_write(A_CTRL, 32'h3);
        bus_write(A_BYTE, 32'hC3);
        catch_frame("R4 frame at div 32", 8'hC3);
        repeat (bit_cyc) @(negedge clk);
        expect_reg("R7 loopback state", A_STATE, 32'h2);
        expect_reg("R7 loopback byte", A_BYTE, 32'hC3);
        loop = 1'b0;
        bit_cyc = 16;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all R) actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        test_tx();
        test_tx_overrun();
        test_rx();
        test_rx_overrun();
        test_rx_errors();
        test_rx_disabled();
        test_div();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule